// File: doc/BRIEF.md
# Dual-Path ADC Trigger Delay Channel

This block is one channel of a conversion-scheduling unit. A single start event launches two independent trigger paths, A and B. Each path drives a pre-trigger level and a one-cycle trigger pulse toward an ADC. A path either fires its trigger straight from the start event or waits until a shared up-counter, cleared by the start event, reaches that path's programmed delay.

Software programs the channel through a small word-wide register port. Address 0 holds the control word, with per-path enables, per-path output selects and two sticky error flags. Addresses 1 and 2 hold the A and B delay values. The channel tracks whether the conversion launched by each path is still in flight. If one path's delay runs out while the other path's conversion has not yet reported completion, the channel records a sequence error for the expiring path and raises its interrupt output.

Top module: `dpath_trig_chan`

## Requirements
- R1: While reset is held and after its release, every output is 0 and the control word at address 0 reads 0x0000.
- R2: Control word at address 0: bit 15 = error A, bit 14 = error B, bits 5:4 = A select, bits 3:2 = B select, bit 1 = A enable, bit 0 = B enable. Bits 13:6 read 0. Address 1 holds the A delay, address 2 the B delay, and address 3 reads 0. Reads are combinational on the address; writes take effect at the clock edge that samples the write strobe.
- R3: While a path's enable bit is 0, that path's pre-trigger and trigger outputs are 0.
- R4: A start sampled on a clock edge loads each path's pre-trigger with "path enabled and select is 00 or 01". The level shows from the next cycle and holds until the next start.
- R5: With select 00 (bypass), a start sampled at edge k gives a trigger pulse exactly one cycle wide in the cycle after edge k.
- R6: With select 01 (delayed), a start sampled at edge k clears the shared counter and runs it. The trigger pulses in the cycle after edge k+D+1, where D is the path's delay. A new start restarts the count from 0. The counter stops at its all-ones value.
- R7: Select codes 10 and 11 behave like a disabled path: no pre-trigger, no trigger, no busy state and no sequence error.
- R8: Each path's busy state sets when that path issues a trigger and clears on a sampled conversion-done pulse. If both happen in the same cycle, the set wins.
- R9: Error A sets when A's delay expires while B is busy. Error B sets when B's delay expires while A is busy.
- R10: Writing 1 to an error bit at address 0 clears it, and writing 0 leaves it unchanged. A new error in the same cycle as a clearing write keeps the flag set.
- R11: The interrupt output is 1 exactly while at least one error flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| start | input | 1 | Start event pulse |
| conv_done | input | 1 | Conversion-complete pulse from the ADC |
| pretrig_a | output | 1 | Path A pre-trigger level |
| trig_a | output | 1 | Path A trigger pulse |
| pretrig_b | output | 1 | Path B pre-trigger level |
| trig_b | output | 1 | Path B trigger pulse |
| seq_irq | output | 1 | Sequence-error interrupt |

## Verification
A corrupted counter or delay compare shows as a trigger that is early, late or missing, and it shows within D+2 cycles of the start event. A stuck or early-cleared busy state does not show on any trigger pin. It appears only at the next expiry of the other path, as a wrong or missing error bit and interrupt, so the bench lets delayed expiries land both before and after conversion-done pulses. The bench compares every output and the read data against a reference model on every cycle, so a divergence is reported in the cycle it first appears.

// File: rtl/trig_chan_pkg.sv
package trig_chan_pkg;
  localparam int REG_W  = 16;
  localparam int NPATH  = 2;
  localparam int PATH_A = 0;
  localparam int PATH_B = 1;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_DLY_A = 2'd1;
  localparam logic [1:0] ADDR_DLY_B = 2'd2;

  localparam int ERR_A_BIT = 15;
  localparam int ERR_B_BIT = 14;
  localparam int SEL_A_LSB = 4;
  localparam int SEL_B_LSB = 2;
  localparam int EN_A_BIT  = 1;
  localparam int EN_B_BIT  = 0;

  typedef enum logic [1:0] {
    OSEL_BYPASS = 2'b00,
    OSEL_DELAY  = 2'b01,
    OSEL_RSV2   = 2'b10,
    OSEL_RSV3   = 2'b11
  } osel_e;
endpackage

// File: rtl/trig_rst_sync.sv
module trig_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/trig_chan_regs.sv
module trig_chan_regs
  import trig_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [1:0]                  addr,
  input  logic [REG_W-1:0]            wdata,
  input  logic [NPATH-1:0]            err_set,
  output logic [REG_W-1:0]            rdata,
  output logic [NPATH-1:0]            en_o,
  output logic [NPATH-1:0][1:0]       sel_o,
  output logic [NPATH-1:0][CNT_W-1:0] dly_o,
  output logic [NPATH-1:0]            err_o
);
  logic [NPATH-1:0]            en_q, en_d;
  logic [NPATH-1:0][1:0]       sel_q, sel_d;
  logic [NPATH-1:0][CNT_W-1:0] dly_q, dly_d;
  logic [NPATH-1:0]            err_q, err_d;
  logic [NPATH-1:0]            err_clr;
  logic                        ctrl_we, dly_a_we, dly_b_we, cfg_ce;

  assign ctrl_we  = wr && (addr == ADDR_CTRL);
  assign dly_a_we = wr && (addr == ADDR_DLY_A);
  assign dly_b_we = wr && (addr == ADDR_DLY_B);
  assign cfg_ce   = ctrl_we || dly_a_we || dly_b_we;

  always_comb begin
    en_d    = en_q;
    sel_d   = sel_q;
    dly_d   = dly_q;
    err_clr = '0;
    if (ctrl_we) begin
      en_d[PATH_A]       = wdata[EN_A_BIT];
      en_d[PATH_B]       = wdata[EN_B_BIT];
      sel_d[PATH_A]      = wdata[SEL_A_LSB +: 2];
      sel_d[PATH_B]      = wdata[SEL_B_LSB +: 2];
      err_clr[PATH_A]    = wdata[ERR_A_BIT];
      err_clr[PATH_B]    = wdata[ERR_B_BIT];
    end
    if (dly_a_we) dly_d[PATH_A] = wdata[CNT_W-1:0];
    if (dly_b_we) dly_d[PATH_B] = wdata[CNT_W-1:0];
    // a fresh error outranks a clearing write in the same cycle
    err_d = err_set | (err_q & ~err_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sel_q <= '0;
      dly_q <= '0;
    end else if (cfg_ce) begin
      en_q  <= en_d;
      sel_q <= sel_d;
      dly_q <= dly_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_d;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CTRL: begin
        rdata[ERR_A_BIT]       = err_q[PATH_A];
        rdata[ERR_B_BIT]       = err_q[PATH_B];
        rdata[SEL_A_LSB +: 2]  = sel_q[PATH_A];
        rdata[SEL_B_LSB +: 2]  = sel_q[PATH_B];
        rdata[EN_A_BIT]        = en_q[PATH_A];
        rdata[EN_B_BIT]        = en_q[PATH_B];
      end
      ADDR_DLY_A: rdata = REG_W'(dly_q[PATH_A]);
      ADDR_DLY_B: rdata = REG_W'(dly_q[PATH_B]);
      default:    rdata = '0;
    endcase
  end

  assign en_o  = en_q;
  assign sel_o = sel_q;
  assign dly_o = dly_q;
  assign err_o = err_q;
endmodule

// File: rtl/trig_delay_counter.sv
module trig_delay_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             cnt_ce;

  assign cnt_ce = start || run_q;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start) begin
      cnt_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q == CNT_MAX) run_d = 1'b0;
      else                  cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
endmodule

// File: rtl/trig_path.sv
module trig_path
  import trig_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       sel,
  input  logic [CNT_W-1:0] dly,
  input  logic [CNT_W-1:0] cnt,
  input  logic             run,
  input  logic             start,
  input  logic             conv_done,
  input  logic             other_busy,
  output logic             pretrig_o,
  output logic             trig_o,
  output logic             busy_o,
  output logic             seq_err_o
);
  osel_e mode;
  logic  active, bypass_ev, expire_ev;
  logic  pre_q, pre_d, trig_q, trig_d, busy_q, busy_d;

  assign mode      = osel_e'(sel);
  assign active    = en && (mode == OSEL_BYPASS || mode == OSEL_DELAY);
  assign bypass_ev = start && active && (mode == OSEL_BYPASS);
  assign expire_ev = run && (cnt == dly) && active && (mode == OSEL_DELAY);
  assign seq_err_o = expire_ev && other_busy;

  always_comb begin
    trig_d = bypass_ev || expire_ev;
    pre_d  = start ? active : pre_q;
    if (trig_d)         busy_d = 1'b1;
    else if (conv_done) busy_d = 1'b0;
    else                busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= 1'b0;
      trig_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      trig_q <= trig_d;
      busy_q <= busy_d;
    end
  end

  assign pretrig_o = pre_q && active;
  assign trig_o    = trig_q && active;
  assign busy_o    = busy_q;
endmodule

// File: rtl/dpath_trig_chan.sv
module dpath_trig_chan
  import trig_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             start,
  input  logic             conv_done,
  output logic             pretrig_a,
  output logic             trig_a,
  output logic             pretrig_b,
  output logic             trig_b,
  output logic             seq_irq
);
  logic                        rst_int_n;
  logic [NPATH-1:0]            path_en;
  logic [NPATH-1:0][1:0]       path_sel;
  logic [NPATH-1:0][CNT_W-1:0] path_dly;
  logic [NPATH-1:0]            err_flag;
  logic [NPATH-1:0]            path_busy;
  logic [NPATH-1:0]            path_err;
  logic [NPATH-1:0]            path_pre;
  logic [NPATH-1:0]            path_trig;
  logic [CNT_W-1:0]            cnt;
  logic                        run;

  trig_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  trig_chan_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .err_set (path_err),
    .rdata   (reg_rdata),
    .en_o    (path_en),
    .sel_o   (path_sel),
    .dly_o   (path_dly),
    .err_o   (err_flag)
  );

  trig_delay_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (start),
    .cnt_o (cnt),
    .run_o (run)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    trig_path #(.CNT_W(CNT_W)) u_path (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .en         (path_en[p]),
      .sel        (path_sel[p]),
      .dly        (path_dly[p]),
      .cnt        (cnt),
      .run        (run),
      .start      (start),
      .conv_done  (conv_done),
      .other_busy (path_busy[NPATH-1-p]),
      .pretrig_o  (path_pre[p]),
      .trig_o     (path_trig[p]),
      .busy_o     (path_busy[p]),
      .seq_err_o  (path_err[p])
    );
  end

  assign pretrig_a = path_pre[PATH_A];
  assign trig_a    = path_trig[PATH_A];
  assign pretrig_b = path_pre[PATH_B];
  assign trig_b    = path_trig[PATH_B];
  assign seq_irq   = |err_flag;
endmodule

// File: rtl/dpath_trig_chan_chk.sv
module dpath_trig_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        start,
  input logic        pretrig_a,
  input logic        trig_a,
  input logic        pretrig_b,
  input logic        trig_b,
  input logic        seq_irq,
  input logic [1:0]  path_en,
  input logic [3:0]  path_sel,
  input logic [1:0]  path_busy,
  input logic [1:0]  err_flag
);
  // R3
  dis_a_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !path_en[0] |-> (!pretrig_a && !trig_a));
  // R3
  dis_b_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !path_en[1] |-> (!pretrig_b && !trig_b));
  // R5
  bypass_a_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && path_en[0] && path_sel[1:0] == 2'b00 && !reg_wr) |=> trig_a);
  // R7
  rsv_a_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    path_sel[1] |-> (!pretrig_a && !trig_a));
  // R7
  rsv_b_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    path_sel[3] |-> (!pretrig_b && !trig_b));
  // R8
  busy_on_trig_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_a |-> path_busy[0]);
  // R9
  err_a_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag[0]) |-> $past(path_busy[1]));
  // R9
  err_b_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag[1]) |-> $past(path_busy[0]));
  // R10
  err_a_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag[0] && !(reg_wr && reg_addr == 2'd0 && reg_wdata[15])) |=> err_flag[0]);
  // R11
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_irq == (err_flag != 2'b00));
endmodule

bind dpath_trig_chan dpath_trig_chan_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .start     (start),
  .pretrig_a (pretrig_a),
  .trig_a    (trig_a),
  .pretrig_b (pretrig_b),
  .trig_b    (trig_b),
  .seq_irq   (seq_irq),
  .path_en   (path_en),
  .path_sel  (path_sel),
  .path_busy (path_busy),
  .err_flag  (err_flag)
);

// File: tb/tb_dpath_trig_chan.sv
module tb_dpath_trig_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic        start = 1'b0;
  logic        conv_done = 1'b0;
  logic [15:0] reg_rdata;
  logic        pretrig_a, trig_a, pretrig_b, trig_b, seq_irq;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  dpath_trig_chan dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start(start),
    .conv_done(conv_done), .pretrig_a(pretrig_a), .trig_a(trig_a),
    .pretrig_b(pretrig_b), .trig_b(trig_b), .seq_irq(seq_irq)
  );

  // ---------------- reference model ----------------
  int m_rcnt;
  int m_cnt;
  bit m_run;
  bit m_en[2];
  int m_sel[2];
  int m_dly[2];
  bit m_pre[2];
  bit m_trg[2];
  bit m_busy[2];
  bit m_err[2];

  function automatic bit m_active(int p);
    return m_en[p] && (m_sel[p] < 2);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rcnt = 0; m_cnt = 0; m_run = 0;
      for (int p = 0; p < 2; p++) begin
        m_en[p] = 0; m_sel[p] = 0; m_dly[p] = 0;
        m_pre[p] = 0; m_trg[p] = 0; m_busy[p] = 0; m_err[p] = 0;
      end
    end else if (m_rcnt < 2) begin
      m_rcnt++;
    end else begin
      bit exp_ev[2];
      bit tnext[2];
      bit eset[2];
      bit clr[2];
      for (int p = 0; p < 2; p++) begin
        exp_ev[p] = m_run && (m_cnt == m_dly[p]) && m_active(p) && m_sel[p] == 1;
        tnext[p]  = (start && m_active(p) && m_sel[p] == 0) || exp_ev[p];
        eset[p]   = exp_ev[p] && m_busy[1-p];
      end
      for (int p = 0; p < 2; p++) begin
        if (tnext[p]) m_busy[p] = 1;
        else if (conv_done) m_busy[p] = 0;
        m_trg[p] = tnext[p];
        if (start) m_pre[p] = m_active(p);
      end
      if (start) begin m_cnt = 0; m_run = 1; end
      else if (m_run) begin
        if (m_cnt == 65535) m_run = 0; else m_cnt++;
      end
      clr[0] = reg_wr && reg_addr == 0 && reg_wdata[15];
      clr[1] = reg_wr && reg_addr == 0 && reg_wdata[14];
      for (int p = 0; p < 2; p++) m_err[p] = eset[p] || (m_err[p] && !clr[p]);
      if (reg_wr && reg_addr == 0) begin
        m_en[0] = reg_wdata[1]; m_en[1] = reg_wdata[0];
        m_sel[0] = int'(reg_wdata[5:4]); m_sel[1] = int'(reg_wdata[3:2]);
      end
      if (reg_wr && reg_addr == 1) m_dly[0] = int'(reg_wdata);
      if (reg_wr && reg_addr == 2) m_dly[1] = int'(reg_wdata);
    end
  end

  function automatic logic [15:0] m_read(logic [1:0] a);
    logic [15:0] v = 16'h0;
    case (a)
      2'd0: begin
        v[15] = m_err[0]; v[14] = m_err[1];
        v[5:4] = m_sel[0][1:0]; v[3:2] = m_sel[1][1:0];
        v[1] = m_en[0]; v[0] = m_en[1];
      end
      2'd1: v = m_dly[0][15:0];
      2'd2: v = m_dly[1][15:0];
      default: v = 16'h0;
    endcase
    return v;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done_flag) begin
      chk("R4 pretrig_a", 16'(pretrig_a), 16'(m_pre[0] && m_active(0)));
      chk("R4 pretrig_b", 16'(pretrig_b), 16'(m_pre[1] && m_active(1)));
      chk("R5 R6 trig_a", 16'(trig_a), 16'(m_trg[0] && m_active(0)));
      chk("R5 R6 trig_b", 16'(trig_b), 16'(m_trg[1] && m_active(1)));
      chk("R11 seq_irq", 16'(seq_irq), 16'(m_err[0] || m_err[1]));
      chk("R2 reg_rdata", reg_rdata, m_read(reg_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(bit s = 0, bit d = 0);
    start = s; conv_done = d;
    @(posedge clk); #1;
    start = 0; conv_done = 0; reg_wr = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] v);
    reg_wr = 1; reg_addr = a; reg_wdata = v;
    @(posedge clk); #1;
    reg_wr = 0; reg_addr = 2'd0;
  endtask

  task automatic rd(logic [1:0] a, logic [15:0] exp, string tag);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
    @(posedge clk); #1;
    reg_addr = 2'd0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  // watchdog
  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 outputs in reset", {11'd0, pretrig_a, trig_a, pretrig_b, trig_b, seq_irq}, 16'h0);
    rst_n = 1;
    idle(4);
    rd(2'd0, 16'h0000, "R1 ctrl after reset");

    // R2: layout, reserved bits, delay regs, unused address
    wr(2'd0, 16'h3FFF);
    rd(2'd0, 16'h003F, "R2 ctrl readback reserved zero");
    wr(2'd1, 16'hA5C3);
    rd(2'd1, 16'hA5C3, "R2 delay A readback");
    wr(2'd2, 16'h0123);
    rd(2'd2, 16'h0123, "R2 delay B readback");
    rd(2'd3, 16'h0000, "R2 address 3 reads zero");

    // R7: both reserved codes, both paths enabled
    wr(2'd0, 16'h002B);        // A sel 10, B sel 10, both enabled
    cyc(1); idle(3);
    wr(2'd0, 16'h003F);        // both sel 11
    cyc(1); idle(3);
    rd(2'd0, 16'h003F, "R7 no error from reserved codes");

    // R3: disabled paths in bypass
    wr(2'd0, 16'h0000);
    cyc(1); idle(3);

    // R5: bypass on both paths
    wr(2'd0, 16'h0003);
    cyc(1);
    @(negedge clk);
    chk("R5 trig_a bypass pulse", 16'(trig_a), 16'h1);
    chk("R4 pretrig_a level", 16'(pretrig_a), 16'h1);
    @(posedge clk); #1;
    @(negedge clk);
    chk("R5 trig_a single cycle", 16'(trig_a), 16'h0);
    @(posedge clk); #1;
    cyc(0, 1);

    // R6 R9: both delayed, no done, B expires while A busy
    wr(2'd1, 16'd5);
    wr(2'd2, 16'd9);
    wr(2'd0, 16'h0017);        // A sel 01, B sel 01, both enabled
    cyc(1); idle(15);
    rd(2'd0, 16'h4017, "R9 error B set by B expiry while A busy");
    // R10: write 0 has no effect, write 1 clears
    wr(2'd0, 16'h0017);
    rd(2'd0, 16'h4017, "R10 writing zero keeps error B");
    wr(2'd0, 16'h4017);
    rd(2'd0, 16'h0017, "R10 writing one clears error B");
    cyc(0, 1);

    // R8: done arrives before B expiry, no error
    cyc(1); idle(6);
    cyc(0, 1); idle(8);
    rd(2'd0, 16'h0017, "R8 done clears busy so no error");

    // R9: A delayed 3, B bypass, A expires while B busy
    wr(2'd1, 16'd3);
    wr(2'd0, 16'h0013);        // A sel 01, B sel 00
    cyc(1); idle(6);
    rd(2'd0, 16'h8013, "R9 error A set");
    // R10: clear in the same cycle a new error A arises
    cyc(1); idle(3);           // start sampled at edge k, idles at k+1..k+3
    wr(2'd0, 16'h8013);        // sampled at k+4 with the expiry
    rd(2'd0, 16'h8013, "R10 new error beats clear");
    wr(2'd0, 16'h8013);
    rd(2'd0, 16'h0013, "R10 clear later succeeds");

    // R6: restart mid-count
    cyc(0, 1);
    wr(2'd1, 16'd6);
    wr(2'd0, 16'h0012);        // A delayed, B disabled
    cyc(1); idle(3);
    cyc(1); idle(10);
    cyc(0, 1);

    // R6: zero delay on A
    wr(2'd1, 16'd0);
    cyc(1); idle(4);

    // R3: disable mid-run forces outputs low
    wr(2'd1, 16'd4);
    cyc(1); idle(2);
    wr(2'd0, 16'h0000);
    idle(6);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule